// File: doc/BRIEF.md
# FIFO serial port register block

This block is the register front end of a FIFO-style serial port. It sits on a simple synchronous bus. The bus has separate write and read addresses, so one write and one read can happen in the same cycle. The block holds the port's configuration registers: operating mode, bit rate, control, FIFO control and port-pin value. It also keeps five status flags: transmit-end, transmit-empty, break, receive-full and data-ready.

A byte written to the transmit-data register goes out at once on a byte strobe interface. Transmission is treated as finishing instantly. Shifting bits onto the line, baud generation, reception and interrupts belong to other blocks. The receive count therefore always reads zero.

Status flags are cleared by writing a zero to their bit. While the transmitter is enabled, software clears transmit-empty and transmit-end, and the next status read sets them again. Turning the transmitter off forces transmit-end.

Top module: `serport_regs`

## Requirements
- R1: After reset, reads return these values. Mode (0x00) is 0x00. Bit rate (0x04) is 0xFF. Control (0x08) is 0x20. Transmit data (0x0C) is 0x00. FIFO control (0x18) is 0x0000. Port (0x20) is 0x00. Status (0x10) is 0x0060. tx_strobe and bus_err are low.
- R2: Writes store the following values, and a read of the same offset returns them zero-extended. Mode stores the low byte ANDed with 0x7B. Control stores the low byte ANDed with 0xFB. Bit rate and port store the low byte. FIFO control stores all 16 bits.
- R3: A write to 0x0C gives one tx_strobe pulse in the next cycle, with tx_byte equal to the written low byte. The byte is latched, so a read of 0x0C returns it. The write clears transmit-empty.
- R4: The status word places transmit-end at bit 6, transmit-empty at bit 5, break at bit 4, receive-full at bit 1 and data-ready at bit 0. All other bits read as zero.
- R5: A write to status clears each flag whose bit is written 0. A flag whose bit is written 1 keeps its value.
- R6: A control write whose bit 5 (transmit enable) is 0 sets transmit-end.
- R7: A status read returns the flags as they were before the read. If control bit 5 is 1, the read then sets transmit-empty and transmit-end. If control bit 5 is 0, the read leaves the flags unchanged.
- R8: Reads of 0x1C (receive count) and 0x24 (line status) return 0. A write to 0x24 raises no error and changes nothing.
- R9: An access to an offset outside the decoded set (for example 0x14, any offset that is not a multiple of 4, or any offset of 0x28 and above) pulses bus_err for exactly one cycle, in the cycle after the access. A write to 0x1C does the same. An undecoded read returns 0xFFFF, and an undecoded write changes nothing.
- R10: Read data appears in the cycle after the read strobe and holds until the next read. A write takes effect at the edge where it is sampled, so a read of the same offset in the same cycle returns the old value.
- R11: Two operations can fall in the same cycle: a status read with the transmitter enabled, and a write to 0x0C. In that case transmit-empty ends cleared, and transmit-end ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_waddr | input | 6 | Write byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_raddr | input | 6 | Read byte offset |
| bus_rdata | output | 16 | Read data, registered |
| bus_err | output | 1 | One-cycle error pulse for an undecoded access or a receive-count write |
| tx_byte | output | 8 | Last byte written for transmission |
| tx_strobe | output | 1 | One-cycle pulse when a byte is emitted |

## Verification
Two functions can fall in the same cycle. A status read while the transmitter is enabled sets transmit-empty, and a transmit-data write clears it. The bench provokes this by issuing a read of 0x10 and a write of 0x0C in one cycle, after first clearing all flags. It judges the result in two ways. The read must return the flags as they were before that cycle. A later read, taken with the transmitter off so that no further re-set can occur, must show transmit-end set and transmit-empty clear.

// File: rtl/serport_pkg.sv
package serport_pkg;

  typedef enum logic [3:0] {
    SEL_MODE, SEL_BRATE, SEL_CTRL, SEL_TXD, SEL_STAT,
    SEL_FCTL, SEL_RCNT, SEL_PORT, SEL_LSTAT, SEL_NONE
  } sel_e;

  localparam int OFS_MODE  = 'h00;
  localparam int OFS_BRATE = 'h04;
  localparam int OFS_CTRL  = 'h08;
  localparam int OFS_TXD   = 'h0C;
  localparam int OFS_STAT  = 'h10;
  localparam int OFS_FCTL  = 'h18;
  localparam int OFS_RCNT  = 'h1C;
  localparam int OFS_PORT  = 'h20;
  localparam int OFS_LSTAT = 'h24;

  localparam int BIT_TEND = 6;
  localparam int BIT_TDE  = 5;
  localparam int BIT_BRK  = 4;
  localparam int BIT_RDF  = 1;
  localparam int BIT_DR   = 0;
  localparam int BIT_TXEN = 5;

  localparam logic [7:0] MODE_KEEP = 8'h7B;
  localparam logic [7:0] CTRL_KEEP = 8'hFB;
  localparam logic [7:0] BRATE_RST = 8'hFF;
  localparam logic [7:0] CTRL_RST  = 8'h20;

  typedef struct packed {
    logic tend;
    logic tde;
    logic brk;
    logic rdf;
    logic dr;
  } flags_t;

endpackage

// File: rtl/serport_decode.sv
module serport_decode
  import serport_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              strobe,
  output sel_e              sel
);

  always_comb begin
    sel = SEL_NONE;
    if (strobe) begin
      case (addr)
        ADDR_W'(OFS_MODE):  sel = SEL_MODE;
        ADDR_W'(OFS_BRATE): sel = SEL_BRATE;
        ADDR_W'(OFS_CTRL):  sel = SEL_CTRL;
        ADDR_W'(OFS_TXD):   sel = SEL_TXD;
        ADDR_W'(OFS_STAT):  sel = SEL_STAT;
        ADDR_W'(OFS_FCTL):  sel = SEL_FCTL;
        ADDR_W'(OFS_RCNT):  sel = SEL_RCNT;
        ADDR_W'(OFS_PORT):  sel = SEL_PORT;
        ADDR_W'(OFS_LSTAT): sel = SEL_LSTAT;
        default:            sel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/serport_cfg.sv
module serport_cfg
  import serport_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sel_e              wsel,
  input  logic [DATA_W-1:0] wdata,
  output logic [BYTE_W-1:0] mode_q,
  output logic [BYTE_W-1:0] brate_q,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] fctl_q,
  output logic [BYTE_W-1:0] port_q,
  output logic [BYTE_W-1:0] txd_q,
  output logic              fire_q
);

  logic [BYTE_W-1:0] lo;
  logic [BYTE_W-1:0] mode_d, brate_d, ctrl_d, port_d, txd_d;
  logic [DATA_W-1:0] fctl_d;
  logic              fire_d;

  assign lo = wdata[BYTE_W-1:0];

  always_comb begin
    mode_d  = mode_q;
    brate_d = brate_q;
    ctrl_d  = ctrl_q;
    fctl_d  = fctl_q;
    port_d  = port_q;
    txd_d   = txd_q;
    fire_d  = 1'b0;
    case (wsel)
      SEL_MODE:  mode_d  = lo & BYTE_W'(MODE_KEEP);
      SEL_BRATE: brate_d = lo;
      SEL_CTRL:  ctrl_d  = lo & BYTE_W'(CTRL_KEEP);
      SEL_FCTL:  fctl_d  = wdata;
      SEL_PORT:  port_d  = lo;
      SEL_TXD: begin
        txd_d  = lo;
        fire_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      brate_q <= BYTE_W'(BRATE_RST);
      ctrl_q  <= BYTE_W'(CTRL_RST);
      fctl_q  <= '0;
      port_q  <= '0;
      txd_q   <= '0;
      fire_q  <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      brate_q <= brate_d;
      ctrl_q  <= ctrl_d;
      fctl_q  <= fctl_d;
      port_q  <= port_d;
      txd_q   <= txd_d;
      fire_q  <= fire_d;
    end
  end

endmodule

// File: rtl/serport_flags.sv
module serport_flags
  import serport_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sts_wr,
  input  flags_t keep,
  input  logic   ctl_wr,
  input  logic   ctl_txen,
  input  logic   tx_wr,
  input  logic   sts_rd,
  input  logic   tx_en,
  output flags_t flags_q
);

  flags_t flags_d;

  always_comb begin
    flags_d = flags_q;
    if (sts_wr) flags_d = flags_d & keep;
    if (ctl_wr && !ctl_txen) flags_d.tend = 1'b1;
    if (sts_rd && tx_en) begin
      flags_d.tend = 1'b1;
      flags_d.tde  = 1'b1;
    end
    if (tx_wr) flags_d.tde = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '{tend: 1'b1, tde: 1'b1, brk: 1'b0, rdf: 1'b0, dr: 1'b0};
    else        flags_q <= flags_d;
  end

  a_r3_txd_write_clears_tde: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> !flags_q.tde);
  a_r6_txen_off_sets_tend: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !ctl_txen |=> flags_q.tend);
  a_r7_read_resets_flags: assert property (@(posedge clk) disable iff (!rst_n)
    sts_rd && tx_en && !tx_wr |=> flags_q.tde && flags_q.tend);
  a_r5_zero_clears_break: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr && !keep.brk |=> !flags_q.brk);
  a_r11_write_beats_reset: assert property (@(posedge clk) disable iff (!rst_n)
    sts_rd && tx_en && tx_wr |=> flags_q.tend && !flags_q.tde);

endmodule

// File: rtl/serport_regs.sv
module serport_regs
  import serport_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_waddr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_raddr,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_strobe
);

  sel_e wsel, rsel;
  logic [BYTE_W-1:0] mode_q, brate_q, ctrl_q, port_q, txd_q;
  logic [DATA_W-1:0] fctl_q;
  flags_t            flags_q, keep;
  logic [DATA_W-1:0] stat_word, rdata_d;
  logic              err_d;

  serport_decode #(.ADDR_W(ADDR_W)) i_wdec (
    .addr(bus_waddr), .strobe(bus_wr), .sel(wsel));
  serport_decode #(.ADDR_W(ADDR_W)) i_rdec (
    .addr(bus_raddr), .strobe(bus_rd), .sel(rsel));

  serport_cfg #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) i_cfg (
    .clk(clk), .rst_n(rst_n), .wsel(wsel), .wdata(bus_wdata),
    .mode_q(mode_q), .brate_q(brate_q), .ctrl_q(ctrl_q), .fctl_q(fctl_q),
    .port_q(port_q), .txd_q(txd_q), .fire_q(tx_strobe));

  assign keep = '{tend: bus_wdata[BIT_TEND], tde: bus_wdata[BIT_TDE],
                  brk:  bus_wdata[BIT_BRK],  rdf: bus_wdata[BIT_RDF],
                  dr:   bus_wdata[BIT_DR]};

  serport_flags i_flags (
    .clk(clk), .rst_n(rst_n),
    .sts_wr(wsel == SEL_STAT), .keep(keep),
    .ctl_wr(wsel == SEL_CTRL), .ctl_txen(bus_wdata[BIT_TXEN]),
    .tx_wr(wsel == SEL_TXD),
    .sts_rd(rsel == SEL_STAT), .tx_en(ctrl_q[BIT_TXEN]),
    .flags_q(flags_q));

  assign tx_byte = txd_q;

  always_comb begin
    stat_word           = '0;
    stat_word[BIT_TEND] = flags_q.tend;
    stat_word[BIT_TDE]  = flags_q.tde;
    stat_word[BIT_BRK]  = flags_q.brk;
    stat_word[BIT_RDF]  = flags_q.rdf;
    stat_word[BIT_DR]   = flags_q.dr;
  end

  always_comb begin
    case (rsel)
      SEL_MODE:  rdata_d = DATA_W'(mode_q);
      SEL_BRATE: rdata_d = DATA_W'(brate_q);
      SEL_CTRL:  rdata_d = DATA_W'(ctrl_q);
      SEL_TXD:   rdata_d = DATA_W'(txd_q);
      SEL_STAT:  rdata_d = stat_word;
      SEL_FCTL:  rdata_d = fctl_q;
      SEL_PORT:  rdata_d = DATA_W'(port_q);
      SEL_RCNT,
      SEL_LSTAT: rdata_d = '0;
      default:   rdata_d = {DATA_W{1'b1}};
    endcase
    err_d = (bus_wr && (wsel == SEL_NONE || wsel == SEL_RCNT)) ||
            (bus_rd && rsel == SEL_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rdata_d;
      bus_err <= err_d;
    end
  end

  a_r9_err_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_rd || bus_wr));
  a_r3_strobe_after_txd_write: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> $past(bus_wr && bus_waddr == ADDR_W'(OFS_TXD)));
  a_r8_lstat_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_waddr == ADDR_W'(OFS_LSTAT) && !bus_rd |=> !bus_err);
  a_r10_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) && $past(rst_n) |-> $stable(bus_rdata));

endmodule

// File: tb/test_serport_regs.sv
module test_serport_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_waddr = '0, bus_raddr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_err;
  logic [7:0]  tx_byte;
  logic        tx_strobe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  tx_q[$];

  always #10 clk = ~clk;

  serport_regs i_serport_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_raddr(bus_raddr),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .tx_byte(tx_byte),
    .tx_strobe(tx_strobe));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input bit w, input logic [5:0] wa, input logic [15:0] wd,
                     input bit r, input logic [5:0] ra);
    @(negedge clk);
    bus_wr = w; bus_waddr = wa; bus_wdata = wd;
    bus_rd = r; bus_raddr = ra;
    @(posedge clk);
    #1;
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    if (a == 6'h0C) tx_q.push_back(d[7:0]);
    bus(1'b1, a, d, 1'b0, '0);
  endtask

  task automatic rd(input logic [5:0] a, input logic [15:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus(1'b0, '0, '0, 1'b1, a);
  endtask

  task automatic chk_err(input logic e, input string tag);
    @(negedge clk);
    check(tag, {15'b0, bus_err}, {15'b0, e});
  endtask

  // monitor: read data scoreboard
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        if (exp_q.size() == 0) check("R10 unexpected read", bus_rdata, 16'hxxxx);
        else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  // monitor: transmit byte scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (tx_strobe === 1'b1) begin
        if (tx_q.size() == 0) check("R3 stray strobe", {8'b0, tx_byte}, 16'hxxxx);
        else check("R3 tx byte", {8'b0, tx_byte}, {8'b0, tx_q.pop_front()});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 tx_strobe", {15'b0, tx_strobe}, 16'h0);
    check("R1 bus_err", {15'b0, bus_err}, 16'h0);
    check("R1 rdata", bus_rdata, 16'h0);
    rd(6'h00, 16'h0000, "R1 mode");
    rd(6'h04, 16'h00FF, "R1 bit rate");
    rd(6'h08, 16'h0020, "R1 control");
    rd(6'h0C, 16'h0000, "R1 tx data");
    rd(6'h18, 16'h0000, "R1 fifo control");
    rd(6'h20, 16'h0000, "R1 port");
    rd(6'h10, 16'h0060, "R1 R4 status");

    wr(6'h00, 16'h00FF); rd(6'h00, 16'h007B, "R2 mode mask");
    wr(6'h04, 16'h1234); rd(6'h04, 16'h0034, "R2 bit rate");
    wr(6'h08, 16'h00FF); rd(6'h08, 16'h00FB, "R2 control mask");
    wr(6'h18, 16'hBEEF); rd(6'h18, 16'hBEEF, "R2 fifo control");
    wr(6'h20, 16'h00A5); rd(6'h20, 16'h00A5, "R2 port");

    wr(6'h0C, 16'h01C3);
    rd(6'h10, 16'h0040, "R3 tde cleared");
    rd(6'h10, 16'h0060, "R7 read re-sets flags");
    rd(6'h0C, 16'h00C3, "R3 tx data latched");

    wr(6'h10, 16'h0040); rd(6'h10, 16'h0040, "R5 keep tend clear tde");
    rd(6'h10, 16'h0060, "R7 re-set after read");
    wr(6'h10, 16'h0000); rd(6'h10, 16'h0000, "R5 clear all");

    wr(6'h08, 16'h0000);
    wr(6'h10, 16'h0000);
    rd(6'h10, 16'h0000, "R7 disabled read");
    rd(6'h10, 16'h0000, "R7 no re-set when disabled");
    wr(6'h08, 16'h0010); rd(6'h10, 16'h0040, "R6 txen off sets tend");
    wr(6'h0C, 16'h0055); rd(6'h10, 16'h0040, "R3 tde stays clear");
    rd(6'h08, 16'h0010, "R2 control readback");

    wr(6'h08, 16'h0020);
    wr(6'h10, 16'h0000);
    exp_q.push_back(16'h0000); tag_q.push_back("R11 collision read pre-value");
    tx_q.push_back(8'h77);
    bus(1'b1, 6'h0C, 16'h0077, 1'b1, 6'h10);
    wr(6'h08, 16'h0000);
    rd(6'h10, 16'h0040, "R11 tde clear tend set");

    wr(6'h24, 16'hFFFF); chk_err(1'b0, "R8 lstat write no error");
    rd(6'h24, 16'h0000, "R8 lstat reads zero");
    rd(6'h1C, 16'h0000, "R8 receive count zero");
    rd(6'h10, 16'h0040, "R8 flags unchanged");

    rd(6'h14, 16'hFFFF, "R9 undecoded read");
    chk_err(1'b1, "R9 err on undecoded read");
    chk_err(1'b0, "R9 err one cycle");
    wr(6'h1C, 16'h0003); chk_err(1'b1, "R9 err on rcnt write");
    rd(6'h1C, 16'h0000, "R9 rcnt still zero");
    wr(6'h28, 16'h0000); chk_err(1'b1, "R9 err beyond window");
    wr(6'h02, 16'h0000); chk_err(1'b1, "R9 err unaligned");
    rd(6'h00, 16'h007B, "R9 mode untouched");
    rd(6'h3C, 16'hFFFF, "R9 high read");
    chk_err(1'b1, "R9 err high read");

    exp_q.push_back(16'h007B); tag_q.push_back("R10 same-cycle old value");
    bus(1'b1, 6'h00, 16'h0001, 1'b1, 6'h00);
    rd(6'h00, 16'h0001, "R10 write took effect");
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 read data holds", bus_rdata, 16'h0001);
    check("R3 all bytes sent", 16'(tx_q.size()), 16'h0);
    check("R10 all reads seen", 16'(exp_q.size()), 16'h0);
    finish_run();
  end

endmodule